// File: doc/BRIEF.md
# Capability List Walker

This block walks the capability linked list of one configuration function. It reaches configuration space through a narrow read port. A request carries a dword-aligned byte offset and uses a valid/ready handshake. The matching 32-bit response arrives on a valid strobe one or more cycles later, and only one read is ever outstanding.

A start pulse begins a walk. The walker first reads the identity dword and checks whether a device is present. It then captures the multifunction flag from the header-type byte and reads the status word to learn whether a capability list is advertised. If a list is advertised, it reads the capabilities pointer and follows the entries until it reaches a zero link.

Each entry is reported on a one-cycle strobe that carries its ID and offset. A one-cycle done pulse closes every walk. The result flags and the entry count then hold until the next start. A loop guard and a pointer-range check turn corrupt or circular lists into an error instead of a hang.

Top module: `cap_list_walker`

## Requirements
- R1: If bits 15:0 of the dword at offset 0x00 equal 0xFFFF, the walk ends after that single read. `no_device` is set, no entries are reported and `list_err` stays clear.
- R2: If bit 20 of the dword at offset 0x04 (status bit 4) is clear, the walk ends with zero entries and no error, and the pointer at 0x34 is never read.
- R3: The first entry offset is bits 7:0 of the dword at 0x34. A masked value of zero ends the walk with zero entries and no error.
- R4: Each entry is one dword read at its offset. The ID is bits 7:0 and the next pointer is bits 15:8. A masked next pointer of zero ends the walk without error.
- R5: The low two bits of every pointer are cleared before use.
- R6: A masked, nonzero pointer below 0x40 stops the walk with `list_err` set. No entry is reported at that pointer.
- R7: Once 48 entries have been reported, a nonzero next pointer stops the walk with `list_err` set. A list of exactly 48 entries that ends in zero completes without error.
- R8: `multi_fn` is bit 23 of the dword at 0x0C (header-type bit 7), captured during the walk. It reads 0 after a no-device walk.
- R9: A read request stays valid with a stable address until it is accepted. No new request is raised before the previous response has arrived.
- R10: `cap_valid` pulses for one cycle per entry, in list order, carrying the ID and the entry offset. `done` pulses for one cycle per walk. `no_device`, `list_err`, `multi_fn` and `cap_count` hold until the next accepted start.
- R11: A start pulse while a walk is in progress is ignored.
- R12: After reset, `busy`, `done`, `cap_valid`, `rd_req_valid` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk when idle |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 8 | Dword-aligned byte offset |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| cap_valid | output | 1 | Entry strobe |
| cap_id | output | 8 | Entry ID |
| cap_offset | output | 8 | Entry offset |
| done | output | 1 | End-of-walk pulse |
| no_device | output | 1 | No device present |
| list_err | output | 1 | Malformed or overlong list |
| multi_fn | output | 1 | Multifunction flag |
| cap_count | output | 6 | Entries reported in the last walk |

## Verification
Several properties are checked on every cycle. A pending request must hold its address until it is accepted. `done` never lasts two cycles. Every reported offset is dword aligned and at or above 0x40. The entry count never exceeds 48, and a no-device finish carries no entries.

Only the bench scenarios can show the rest: the order and content of reported entries, the early exits on a missing device, a missing list or a zero pointer, the error on low or circular pointers, the clean 48-entry list, and that a start pulse during a walk is ignored.

// File: rtl/cap_list_walker.sv
module cap_list_walker #(
  parameter int         MAX_ENTRIES = 48,
  parameter logic [7:0] HDR_END     = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [7:0]  rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic [31:0] rd_rsp_data,
  output logic        busy,
  output logic        cap_valid,
  output logic [7:0]  cap_id,
  output logic [7:0]  cap_offset,
  output logic        done,
  output logic        no_device,
  output logic        list_err,
  output logic        multi_fn,
  output logic [5:0]  cap_count
);
  localparam int CW = 6;

  typedef enum logic [2:0] {S_IDLE, S_VID, S_HDR, S_STAT, S_CPTR, S_CAP} st_t;
  st_t        state;
  logic       issued;
  logic [7:0] ptr;
  logic [7:0] nxt;
  logic       got;

  assign busy         = (state != S_IDLE);
  assign rd_req_valid = busy && !issued;
  assign got          = issued && rd_rsp_valid;
  assign nxt          = ((state == S_CPTR) ? rd_rsp_data[7:0] : rd_rsp_data[15:8]) & 8'hFC;

  always_comb begin
    case (state)
      S_HDR:   rd_req_addr = 8'h0C;
      S_STAT:  rd_req_addr = 8'h04;
      S_CPTR:  rd_req_addr = 8'h34;
      S_CAP:   rd_req_addr = ptr;
      default: rd_req_addr = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      issued     <= 1'b0;
      ptr        <= '0;
      cap_valid  <= 1'b0;
      cap_id     <= '0;
      cap_offset <= '0;
      done       <= 1'b0;
      no_device  <= 1'b0;
      list_err   <= 1'b0;
      multi_fn   <= 1'b0;
      cap_count  <= '0;
    end else begin
      done      <= 1'b0;
      cap_valid <= 1'b0;
      if (rd_req_valid && rd_req_ready) issued <= 1'b1;
      if (state == S_IDLE) begin
        if (start) begin
          state     <= S_VID;
          no_device <= 1'b0;
          list_err  <= 1'b0;
          multi_fn  <= 1'b0;
          cap_count <= '0;
        end
      end else if (got) begin
        issued <= 1'b0;
        case (state)
          S_VID: begin
            if (rd_rsp_data[15:0] == 16'hFFFF) begin
              no_device <= 1'b1;
              done      <= 1'b1;
              state     <= S_IDLE;
            end else state <= S_HDR;
          end
          S_HDR: begin
            multi_fn <= rd_rsp_data[23];
            state    <= S_STAT;
          end
          S_STAT: begin
            if (rd_rsp_data[20]) state <= S_CPTR;
            else begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end
          default: begin
            if (state == S_CAP) begin
              cap_valid  <= 1'b1;
              cap_id     <= rd_rsp_data[7:0];
              cap_offset <= ptr;
              cap_count  <= cap_count + 1'b1;
            end
            if (nxt == 8'h00) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else if (nxt < HDR_END ||
                         (state == S_CAP && cap_count == CW'(MAX_ENTRIES - 1))) begin
              list_err <= 1'b1;
              done     <= 1'b1;
              state    <= S_IDLE;
            end else begin
              ptr   <= nxt;
              state <= S_CAP;
            end
          end
        endcase
      end
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_entry_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> (cap_offset[1:0] == 2'b00) && (cap_offset >= HDR_END));
  assert_count_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_count <= CW'(MAX_ENTRIES));
  assert_nodev_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done && no_device |-> cap_count == 0 && !list_err && !multi_fn);
endmodule

// File: tb/tb_cap_list_walker.sv
module tb_cap_list_walker;
  logic clk = 0, rst_n = 0, start = 0;
  logic rd_req_valid, rd_req_ready = 0, rd_rsp_valid = 0;
  logic [7:0] rd_req_addr, cap_id, cap_offset;
  logic [31:0] rd_rsp_data = 0;
  logic busy, cap_valid, done, no_device, list_err, multi_fn;
  logic [5:0] cap_count;

  always #2.5 clk = ~clk;

  cap_list_walker dut (.*);

  logic [31:0] mem [64];
  int errors = 0, checks = 0, reads = 0, cyc = 0;
  logic waiting = 0; int lat = 0; logic [7:0] raddr = 0;
  logic saw_ptr_read = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_req_ready <= (cyc % 3) != 1;
    rd_rsp_valid <= 1'b0;
    if (rd_req_valid && rd_req_ready && !waiting) begin
      waiting <= 1'b1; lat <= cyc % 4; raddr <= rd_req_addr; reads <= reads + 1;
      if (rd_req_addr == 8'h34) saw_ptr_read <= 1'b1;
    end else if (waiting) begin
      if (lat == 0) begin
        rd_rsp_valid <= 1'b1; rd_rsp_data <= mem[raddr[7:2]]; waiting <= 1'b0;
      end else lat <= lat - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  int eid[$]; int eoff[$]; bit e_nodev, e_err, e_mf;

  task automatic model();
    int p, n;
    eid.delete(); eoff.delete();
    e_nodev = (mem[0][15:0] == 16'hFFFF);
    e_err = 0; e_mf = 0;
    if (e_nodev) return;
    e_mf = mem[3][23];
    if (!mem[1][20]) return;
    p = mem[13][7:0] & 8'hFC; n = 0;
    while (p != 0) begin
      if (p < 8'h40 || n == 48) begin e_err = 1; break; end
      eid.push_back(mem[p/4][7:0]); eoff.push_back(p);
      p = mem[p/4][15:8] & 8'hFC; n++;
    end
  endtask

  task automatic setup(input logic [15:0] vid, input bit caps, input bit mf, input logic [7:0] cptr);
    foreach (mem[i]) mem[i] = 32'h0;
    mem[0] = {16'h1234, vid};
    mem[1] = {11'h0, caps, 4'h0, 16'h0007};
    mem[3] = {8'h0, mf, 7'h0, 16'h0010};
    mem[13] = {24'h0, cptr};
  endtask

  task automatic run(input string req, input bit restart);
    int idx = 0, w = 0;
    model();
    reads = 0; saw_ptr_read = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    while (!done && w < 5000) begin
      if (restart && w == 6) start = 1; else start = 0;
      if (cap_valid) begin
        chk(idx < eid.size(), {req, " R10 extra entry"}, idx, eid.size());
        if (idx < eid.size()) begin
          chk(cap_id == eid[idx], {req, " R4 id"}, cap_id, eid[idx]);
          chk(cap_offset == eoff[idx], {req, " R5 offset"}, cap_offset, eoff[idx]);
        end
        idx++;
      end
      @(negedge clk); w++;
    end
    start = 0;
    chk(w < 5000, {req, " watchdog"}, w, 5000);
    if (cap_valid) idx++;
    chk(idx == eid.size(), {req, " R10 entry count"}, idx, eid.size());
    chk(cap_count == eid.size(), {req, " R10 cap_count"}, cap_count, eid.size());
    chk(no_device == e_nodev, {req, " R1 no_device"}, no_device, e_nodev);
    chk(list_err == e_err, {req, " R6/R7 list_err"}, list_err, e_err);
    chk(multi_fn == e_mf, {req, " R8 multi_fn"}, multi_fn, e_mf);
    @(negedge clk);
    chk(!done && !busy, {req, " R10 done one cycle"}, done, 0);
    chk(no_device == e_nodev && list_err == e_err && multi_fn == e_mf,
        {req, " R10 flags held"}, {no_device, list_err, multi_fn}, {e_nodev, e_err, e_mf});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cap_valid && !rd_req_valid && !no_device && !list_err && !multi_fn && cap_count == 0,
        "R12 reset", {busy, done, cap_valid, rd_req_valid}, 0);
    rst_n = 1; @(negedge clk);

    setup(16'hFFFF, 1, 1, 8'h40);
    run("R1 no device", 0);
    chk(reads == 1, "R1 single read", reads, 1);

    setup(16'h8086, 0, 1, 8'h40);
    mem[16] = 32'h0000_0005;
    run("R2 no list", 0);
    chk(!saw_ptr_read, "R2 pointer unread", saw_ptr_read, 0);

    setup(16'h8086, 1, 0, 8'h03);
    run("R3 zero pointer", 0);

    setup(16'h8086, 1, 1, 8'h43);
    mem[16] = 32'h0000_8101;
    mem[32] = 32'h0000_5205;
    mem[20] = 32'h0000_0310;
    run("R4 R5 R8 chain", 0);

    setup(16'h8086, 1, 0, 8'h50);
    mem[20] = 32'h0000_2011;
    run("R6 low pointer", 0);

    setup(16'h8086, 1, 0, 8'h40);
    mem[16] = 32'h0000_4409;
    mem[17] = 32'h0000_400A;
    run("R7 circular", 0);

    setup(16'h8086, 1, 1, 8'h40);
    for (int i = 16; i < 64; i++) mem[i] = {16'h0, (i == 63) ? 8'h00 : 8'((i + 1) * 4), 8'(i)};
    run("R7 exactly 48", 0);

    setup(16'h8086, 1, 0, 8'h48);
    mem[18] = 32'h0000_4C07;
    mem[19] = 32'h0000_0011;
    run("R11 start while busy", 1);
    chk(reads == 6, "R11 read count", reads, 6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule